// File: doc/BRIEF.md
# Cache Way Select with Fault Injection

This is one pipeline stage of a set-associative data cache. Each request carries the tags, coherence states and stored check bits that the tag array returned for every way of one set. It also carries the requested tag, a miss flag, the request kind (store-buffer write, atomic or other), the way that the replacement policy picked, a per-way data-error vector from the data ECC decoder, and a fault-injection flip mask with its valid bit. The stage decides whether the line is already present. It produces a one-hot way enable for the cache write, flags for replacement and eviction, a tag-error flag, a data-error qualifier and an error-report strobe.

A fault injector XORs a mask onto every stored tag to emulate a corrupted tag. The stage uses the flipped tags only for error detection. The hit decision uses the tags exactly as stored. A line that is already present therefore still hits during an injection, and no second copy of it is ever allocated. The injection valid bit travels with the request and is used in the same stage as the tags it belongs to.

The request side is valid/ready and so is the result side. The stage holds one result in a register. A request is accepted when `in_valid` and `in_ready` are both high, and its result appears on the outputs from the next cycle. `in_ready` is high when the register is empty or the consumer takes the held result in the same cycle. While `out_valid` is high and `out_ready` is low, every output stays constant.

Top module: `cache_way_select`

## Requirements
- R1: A request needs replacement when `in_miss` is 1 and no way matches. In that case `out_need_repl` is 1 and `out_way_en` is the one-hot decode of `in_repl_way`.
- R2: A way matches when its coherence state is not 0 (0 means invalid; 1, 2 and 3 are valid states) and its stored tag equals `in_req_tag`. When there is no replacement, `out_way_en` is the one-hot of the matching way. If several ways match, the lowest-index way wins. If no way matches, `out_way_en` is all-zero.
- R3: `out_way_en` is one-hot or all-zero for every accepted request.
- R4: `out_need_evict` is 1 exactly when replacement is needed and the state of the way named by `in_repl_way` is not 0.
- R5: While `inj_valid` is 1, matching uses the stored tags without the flip. A line that is present therefore selects its own way even on a miss (a permission upgrade), and writing the result never leaves two valid ways holding the same tag.
- R6: The toggled tag of a way is its stored tag XOR `inj_mask[TAG_W-1:0]` when `inj_valid` is 1, and the stored tag otherwise. `out_tag_err` is 1 when, for any way and regardless of its state, the XOR-reduction of the toggled tag differs from that way's bit in `in_chk`. A stored check bit is the even-parity bit of the tag.
- R7: `out_data_err` is 1 only when the bit of `in_data_err` for the selected hit way is 1. Data errors on other ways, and any data error on a request that needs replacement, are ignored.
- R8: `out_err_report` equals (`out_tag_err` OR `out_data_err`), except that it is forced to 0 for store-buffer writes (`in_store`) and atomics (`in_amo`) when `in_miss` is 0. A refill (`in_miss` = 1) still reports.
- R9: `in_ready` = !`out_valid` OR `out_ready`. A result appears on the outputs the cycle after its request is accepted. All outputs hold steady while `out_valid` is 1 and `out_ready` is 0.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Stage can accept a request |
| in_req_tag | input | TAG_W | Tag of the requested line |
| in_miss | input | 1 | Request is a refill / miss request |
| in_store | input | 1 | Request is a store-buffer write |
| in_amo | input | 1 | Request is an atomic |
| in_repl_way | input | IDX_W | Way chosen by the replacement policy |
| in_tags | input | WAYS*TAG_W | Stored tag of each way |
| in_states | input | WAYS*2 | Coherence state of each way |
| in_chk | input | WAYS | Stored check bit of each way's tag |
| in_data_err | input | WAYS | Data ECC error seen on each way |
| inj_valid | input | 1 | Tag fault injection active for this request |
| inj_mask | input | MASK_W | Injection flip mask |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_way_en | output | WAYS | One-hot write way enable |
| out_need_repl | output | 1 | Replacement needed |
| out_need_evict | output | 1 | Victim must be evicted |
| out_tag_err | output | 1 | Tag check error on some way |
| out_data_err | output | 1 | Data error on the hit way |
| out_err_report | output | 1 | Error must be reported |

## Verification
Two functions of this block can act on the same request: an injected tag fault and a hit on a present line that is being refilled for a permission upgrade. The bench provokes this by sending a miss whose tag sits in a valid way while a single-bit flip mask is active. It then checks three things on that one result: the way enable points at the present way and not at the replacement victim, the tag-error flag rises, and a model set updated with the result still holds no duplicate tag. A second case applies back-pressure while a new request waits. It checks that the held result stays frozen and that hand-off and acceptance happen on the same edge.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
  localparam int COH_W = 2;
  typedef enum logic [COH_W-1:0] {
    COH_INVALID = 2'd0,
    COH_SHARED  = 2'd1,
    COH_OWNED   = 2'd2,
    COH_DIRTY   = 2'd3
  } coh_e;
endpackage

// File: rtl/wsel_tag_cmp.sv
module wsel_tag_cmp
  import wsel_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int MASK_W = 64
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0][COH_W-1:0] states_i,
  input  logic [WAYS-1:0]            chk_i,
  input  logic [TAG_W-1:0]           req_tag_i,
  input  logic                       inj_valid_i,
  input  logic [MASK_W-1:0]          inj_mask_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       tag_err_o
);
  logic [TAG_W-1:0] flip;
  logic [WAYS-1:0]  par_bad;

  assign flip = inj_valid_i ? inj_mask_i[TAG_W-1:0] : '0;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] toggled;
    logic [TAG_W-1:0] cmp_tag;
    assign toggled    = tags_i[w] ^ flip;
    // during injection the hit path sees the untouched tag
    assign cmp_tag    = inj_valid_i ? tags_i[w] : toggled;
    assign match_o[w] = (coh_e'(states_i[w]) != COH_INVALID) && (cmp_tag == req_tag_i);
    assign par_bad[w] = (^toggled) != chk_i[w];
  end

  assign tag_err_o = |par_bad;
endmodule

// File: rtl/wsel_way_pick.sv
module wsel_way_pick
  import wsel_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int IDX_W = 2
) (
  input  logic [WAYS-1:0]            match_i,
  input  logic [WAYS-1:0][COH_W-1:0] states_i,
  input  logic                       miss_i,
  input  logic [IDX_W-1:0]           repl_i,
  output logic [WAYS-1:0]            way_en_o,
  output logic [WAYS-1:0]            hit_oh_o,
  output logic                       need_repl_o,
  output logic                       need_evict_o
);
  logic [WAYS-1:0] first;

  always_comb begin
    first = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) first = WAYS'(1) << w;
    end
  end

  assign need_repl_o  = miss_i && !(|match_i);
  assign hit_oh_o     = need_repl_o ? '0 : first;
  assign way_en_o     = need_repl_o ? (WAYS'(1) << repl_i) : first;
  assign need_evict_o = need_repl_o && (coh_e'(states_i[repl_i]) != COH_INVALID);

  always_comb begin
    assert_pick_onehot_R3: assert ($onehot0(way_en_o));
  end
endmodule

// File: rtl/wsel_err_qual.sv
module wsel_err_qual #(
  parameter int WAYS = 4
) (
  input  logic            tag_err_i,
  input  logic [WAYS-1:0] data_err_i,
  input  logic [WAYS-1:0] hit_oh_i,
  input  logic            miss_i,
  input  logic            store_i,
  input  logic            amo_i,
  output logic            data_err_o,
  output logic            report_o
);
  logic quiet;
  assign data_err_o = |(data_err_i & hit_oh_i);
  // refills still report even when flagged store/atomic
  assign quiet      = (store_i || amo_i) && !miss_i;
  assign report_o   = (tag_err_i || data_err_o) && !quiet;
endmodule

// File: rtl/cache_way_select.sv
module cache_way_select
  import wsel_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int MASK_W = 64,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [TAG_W-1:0]           in_req_tag,
  input  logic                       in_miss,
  input  logic                       in_store,
  input  logic                       in_amo,
  input  logic [IDX_W-1:0]           in_repl_way,
  input  logic [WAYS-1:0][TAG_W-1:0] in_tags,
  input  logic [WAYS-1:0][COH_W-1:0] in_states,
  input  logic [WAYS-1:0]            in_chk,
  input  logic [WAYS-1:0]            in_data_err,
  input  logic                       inj_valid,
  input  logic [MASK_W-1:0]          inj_mask,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WAYS-1:0]            out_way_en,
  output logic                       out_need_repl,
  output logic                       out_need_evict,
  output logic                       out_tag_err,
  output logic                       out_data_err,
  output logic                       out_err_report
);
  logic [WAYS-1:0] match, way_en, hit_oh;
  logic            tag_err, need_repl, need_evict, data_err, report;
  logic            take;

  wsel_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W), .MASK_W(MASK_W)) u_cmp (
    .tags_i(in_tags), .states_i(in_states), .chk_i(in_chk),
    .req_tag_i(in_req_tag), .inj_valid_i(inj_valid), .inj_mask_i(inj_mask),
    .match_o(match), .tag_err_o(tag_err)
  );

  wsel_way_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) u_pick (
    .match_i(match), .states_i(in_states), .miss_i(in_miss), .repl_i(in_repl_way),
    .way_en_o(way_en), .hit_oh_o(hit_oh), .need_repl_o(need_repl),
    .need_evict_o(need_evict)
  );

  wsel_err_qual #(.WAYS(WAYS)) u_err (
    .tag_err_i(tag_err), .data_err_i(in_data_err), .hit_oh_i(hit_oh),
    .miss_i(in_miss), .store_i(in_store), .amo_i(in_amo),
    .data_err_o(data_err), .report_o(report)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_way_en     <= '0;
      out_need_repl  <= 1'b0;
      out_need_evict <= 1'b0;
      out_tag_err    <= 1'b0;
      out_data_err   <= 1'b0;
      out_err_report <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_way_en     <= way_en;
        out_need_repl  <= need_repl;
        out_need_evict <= need_evict;
        out_tag_err    <= tag_err;
        out_data_err   <= data_err;
        out_err_report <= report;
      end
    end
  end

  assert_way_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_way_en));
  assert_evict_implies_repl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_need_evict |-> out_need_repl);
  assert_no_data_err_on_repl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_need_repl |-> !out_data_err);
  assert_report_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err_report |-> (out_tag_err || out_data_err));
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_way_en) && $stable(out_err_report)
                                && $stable(out_tag_err) && $stable(out_need_repl));
  assert_repl_has_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_need_repl |-> $countones(out_way_en) == 1);
endmodule

// File: tb/cache_way_select_tb.sv
module cache_way_select_tb_top;
  localparam int WAYS = 4, TAG_W = 8, MASK_W = 16;

  typedef struct packed {
    logic [3:0][7:0] tags;
    logic [3:0][1:0] st;
    logic [3:0]      chkflip;
    logic [3:0]      derr;
    logic [7:0]      rtag;
    logic            miss, store, amo;
    logic [1:0]      repl;
    logic            inj;
    logic [15:0]     mask;
  } vec_t;

  typedef struct packed {
    logic [3:0] way;
    logic repl, evict, terr, derr, rep;
  } exp_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h40302010, 8'h55, 4'h0, 4'h0, 8'h20, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{32'h40302010, 8'h55, 4'h0, 4'h0, 8'h77, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 16'h0000},
    '{32'h40302010, 8'h45, 4'h0, 4'h0, 8'h77, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 16'h0000},
    '{32'h40302010, 8'h55, 4'h0, 4'h4, 8'h30, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{32'h40302010, 8'h55, 4'h0, 4'h1, 8'h30, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{32'h40302010, 8'h55, 4'h1, 4'h0, 8'h20, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{32'h40302010, 8'h55, 4'h1, 4'h0, 8'h99, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 16'h0000},
    '{32'h40302010, 8'h55, 4'h0, 4'h2, 8'h20, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 16'h0000},
    '{32'h20112066, 8'h55, 4'h0, 4'h0, 8'h20, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{32'h40302010, 8'h55, 4'h0, 4'h0, 8'h30, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 16'hff01},
    '{32'h40302010, 8'h55, 4'h0, 4'h0, 8'h10, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 16'h0003}
  };

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [TAG_W-1:0] in_req_tag = '0;
  logic in_miss = 0, in_store = 0, in_amo = 0, inj_valid = 0;
  logic [1:0] in_repl_way = '0;
  logic [WAYS-1:0][TAG_W-1:0] in_tags = '0;
  logic [WAYS-1:0][1:0] in_states = '0;
  logic [WAYS-1:0] in_chk = '0, in_data_err = '0, out_way_en;
  logic [MASK_W-1:0] inj_mask = '0;
  logic out_need_repl, out_need_evict, out_tag_err, out_data_err, out_err_report;

  cache_way_select #(.WAYS(WAYS), .TAG_W(TAG_W), .MASK_W(MASK_W)) dut_i (.*);

  int total = 0, bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(vec_t v);
    exp_t e;
    logic [3:0] m;
    logic [7:0] t;
    e = '0;
    m = '0;
    for (int w = 0; w < 4; w++) m[w] = (v.st[w] != 2'd0) && (v.tags[w] == v.rtag);
    for (int w = 0; w < 4; w++) begin
      t = v.tags[w] ^ (v.inj ? v.mask[7:0] : 8'h00);
      if ((^t) != ((^v.tags[w]) ^ v.chkflip[w])) e.terr = 1'b1;
    end
    e.repl = v.miss && (m == 4'b0);
    if (e.repl) begin
      e.way = 4'b1 << v.repl;
      e.evict = v.st[v.repl] != 2'd0;
    end else begin
      for (int w = 3; w >= 0; w--) if (m[w]) e.way = 4'b1 << w;
      e.derr = |(e.way & v.derr);
    end
    e.rep = (e.terr || e.derr) && !((v.store || v.amo) && !v.miss);
    return e;
  endfunction

  task automatic drive(vec_t v);
    in_tags = v.tags; in_states = v.st; in_data_err = v.derr;
    for (int w = 0; w < 4; w++) in_chk[w] = (^v.tags[w]) ^ v.chkflip[w];
    in_req_tag = v.rtag; in_miss = v.miss; in_store = v.store; in_amo = v.amo;
    in_repl_way = v.repl; inj_valid = v.inj; inj_mask = v.mask;
    in_valid = 1;
  endtask

  task automatic send(vec_t v);
    @(negedge clk); drive(v);
    @(posedge clk);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic check_out(exp_t e, int idx);
    chk($sformatf("R1,R2,R3 v%0d way_en", idx), 32'(out_way_en), 32'(e.way));
    chk($sformatf("R1 v%0d need_repl", idx), 32'(out_need_repl), 32'(e.repl));
    chk($sformatf("R4 v%0d need_evict", idx), 32'(out_need_evict), 32'(e.evict));
    chk($sformatf("R6 v%0d tag_err", idx), 32'(out_tag_err), 32'(e.terr));
    chk($sformatf("R7 v%0d data_err", idx), 32'(out_data_err), 32'(e.derr));
    chk($sformatf("R8 v%0d report", idx), 32'(out_err_report), 32'(e.rep));
    chk($sformatf("R9 v%0d out_valid", idx), 32'(out_valid), 32'd1);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R10 out_valid after reset", 32'(out_valid), 0);
    chk("R10 in_ready after reset", 32'(in_ready), 1);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i]);
      check_out(model(VECS[i]), i);
    end

    // R5: injection plus permission-upgrade miss on a present line
    begin
      vec_t v;
      logic [3:0][7:0] set_tags;
      logic [3:0] dup;
      v = VECS[9];
      send(v);
      chk("R5 upgrade selects present way", 32'(out_way_en), 32'h4);
      chk("R5 no replacement under injection", 32'(out_need_repl), 0);
      chk("R5 tag error raised under injection", 32'(out_tag_err), 1);
      set_tags = v.tags;
      for (int w = 0; w < 4; w++) if (out_way_en[w]) set_tags[w] = v.rtag;
      dup = '0;
      for (int a = 0; a < 4; a++)
        for (int b = a + 1; b < 4; b++)
          if (set_tags[a] == set_tags[b]) dup = 4'hf;
      chk("R5 no duplicate tag after write", 32'(dup), 0);
    end

    // R9: back-pressure, hold, then hand-off and accept on the same edge
    @(negedge clk); out_ready = 0;
    send(VECS[1]);
    @(negedge clk);
    drive(VECS[3]);
    chk("R9 in_ready low while stalled", 32'(in_ready), 0);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R9 held way_en", 32'(out_way_en), 32'h8);
    chk("R9 held need_evict", 32'(out_need_evict), 1);
    chk("R9 in_ready follows out_ready", 32'(in_ready), 0);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk); in_valid = 0;
    chk("R9 new result after hand-off", 32'(out_way_en), 32'h4);
    chk("R9 new data_err after hand-off", 32'(out_data_err), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drains to idle", 32'(out_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule